// File: doc/BRIEF.md
# Atomic Byte-Split Access Bridge for a 16-Bit Counter

This block connects an 8-bit processor data bus to a 16-bit free-running counter so that software can read or load the counter as one 16-bit value, even though the bus carries only one byte per access. Every 16-bit transfer takes two byte accesses: one to a low-byte address and one to a high-byte address. A single shared holding byte (the staging latch) keeps the half that is moved first. The second access then either loads all 16 counter bits in one clock, or returns the half that was captured earlier.

A static ordering input chooses which write order the bridge accepts. In high-first ordering, the high-byte write fills the staging latch and the low-byte write commits. In low-first ordering, the low-byte write fills the latch and the high-byte write commits. Reads always go low byte first, in both orderings. Reading the low byte also captures the live high byte, so the pair of reads is coherent even while the counter keeps running. The ordering input is sampled only while reset is held.

Top module: `wordreg_bridge`

## Requirements
- R1: While reset is held, the counter output, the staging latch and the read data output are all zero.
- R2: In every clock cycle with no committing write, the counter increases by one and wraps from 16'hFFFF to 0.
- R3: With lo_first sampled as 0 (high-first ordering), a write to HI_ADDR (default 4'h5) only loads the staging latch. The counter keeps counting and is not otherwise changed.
- R4: With lo_first sampled as 0, a write to LO_ADDR (default 4'h4) loads the counter with {staging latch, written byte}, and the new value is visible after that clock edge.
- R5: With lo_first sampled as 1 (low-first ordering), a write to LO_ADDR only loads the staging latch, and a later write to HI_ADDR loads the counter with {written byte, staging latch}.
- R6: A committing write takes priority over the increment in its cycle. The value seen after the edge is exactly the committed value, and it counts up from the next cycle on.
- R7: A read of LO_ADDR returns the counter's low byte as it stood before the edge on bus_rdata after that edge. In the same cycle it copies the counter's high byte into the staging latch.
- R8: A read of HI_ADDR returns the staging latch contents, not the live high byte.
- R9: The staging latch is shared: a low-byte read that comes after a filling write replaces the pending byte, and the next commit uses the captured high byte.
- R10: A commit with no fill before it (the wrong write order) uses whatever the staging latch last held, so the result is the stale byte combined with the written byte.
- R11: lo_first is sampled only while reset is held. Changing it after reset does not change the write ordering.
- R12: Accesses to any address other than LO_ADDR and HI_ADDR have no effect on the counter or the staging latch, and reads of such addresses return 0.
- R13: When bus_wr and bus_rd are both high, the write is carried out and the read is ignored, so bus_rdata holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; lo_first is sampled while it is held |
| lo_first | input | 1 | Write ordering: 0 means high byte first, 1 means low byte first |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write byte |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | DATA_W | Registered read byte, valid after the read edge and held until the next read |
| cnt_out | output | 2*DATA_W | Current counter value |

## Verification
The hardest case to reach is the shared staging latch being overwritten between the two halves of a write pair: a filling write, then a low-byte read, then the commit. Randomly chosen bus operations rarely line up in exactly that order. A directed sequence therefore forces it, and also forces the wrong-order commit that has no fill before it. Long random runs in both orderings, with strobes that are sometimes high together and addresses that are sometimes unmapped, are compared every cycle against a bench model of the counter, the latch and the read data.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef struct packed {
    logic fill;
    logic commit;
    logic rd_lo;
    logic rd_hi;
    logic rd_other;
  } wb_ops_t;
endpackage

// File: rtl/wb_decode.sv
module wb_decode #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] LO_ADDR = 4,
  parameter logic [ADDR_W-1:0] HI_ADDR = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_lo_first,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output wb_pkg::wb_ops_t   ops
);
  logic hit_lo, hit_hi, wr_lo, wr_hi, rd_ok;

  assign hit_lo = (addr == LO_ADDR);
  assign hit_hi = (addr == HI_ADDR);
  assign wr_lo  = wr && hit_lo;
  assign wr_hi  = wr && hit_hi;
  assign rd_ok  = rd && !wr;

  always_comb begin
    ops.fill     = mode_lo_first ? wr_lo : wr_hi;
    ops.commit   = mode_lo_first ? wr_hi : wr_lo;
    ops.rd_lo    = rd_ok && hit_lo;
    ops.rd_hi    = rd_ok && hit_hi;
    ops.rd_other = rd_ok && !hit_lo && !hit_hi;
  end

  // R13
  ops_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ops.fill, ops.commit, ops.rd_lo, ops.rd_hi, ops.rd_other}));
endmodule

// File: rtl/wb_staging.sv
module wb_staging #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill,
  input  logic              capture,
  input  logic [DATA_W-1:0] wbyte,
  input  logic [DATA_W-1:0] live_hi,
  output logic [DATA_W-1:0] stage
);
  always_ff @(posedge clk) begin
    if (rst)          stage <= '0;
    else if (capture) stage <= live_hi;
    else if (fill)    stage <= wbyte;
  end

  // R3
  fill_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fill)) |-> stage == $past(wbyte));
  // R9
  capture_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(capture)) |-> stage == $past(live_hi));
endmodule

// File: rtl/wb_counter.sv
module wb_counter #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [REG_W-1:0] commit_val,
  output logic [REG_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (commit) cnt <= commit_val;
    else             cnt <= cnt + 1'b1;
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(commit)) |-> cnt == $past(cnt) + 1'b1);
  // R6
  commit_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(commit)) |-> cnt == $past(commit_val));
endmodule

// File: rtl/wordreg_bridge.sv
module wordreg_bridge #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] LO_ADDR = 4,
  parameter logic [ADDR_W-1:0] HI_ADDR = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lo_first,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [2*DATA_W-1:0] cnt_out
);
  localparam int REG_W = 2 * DATA_W;

  logic              mode_q;
  wb_pkg::wb_ops_t   ops;
  logic [DATA_W-1:0] stage;
  logic [REG_W-1:0]  cnt;
  logic [REG_W-1:0]  commit_val;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= lo_first;
  end

  wb_decode #(.ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) u_dec (
    .clk(clk), .rst(rst), .mode_lo_first(mode_q), .addr(bus_addr),
    .wr(bus_wr), .rd(bus_rd), .ops(ops));

  wb_staging #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst(rst), .fill(ops.fill), .capture(ops.rd_lo),
    .wbyte(bus_wdata), .live_hi(cnt[REG_W-1:DATA_W]), .stage(stage));

  assign commit_val = mode_q ? {bus_wdata, stage} : {stage, bus_wdata};

  wb_counter #(.REG_W(REG_W)) u_cnt (
    .clk(clk), .rst(rst), .commit(ops.commit), .commit_val(commit_val), .cnt(cnt));

  always_ff @(posedge clk) begin
    if (rst)               bus_rdata <= '0;
    else if (ops.rd_lo)    bus_rdata <= cnt[DATA_W-1:0];
    else if (ops.rd_hi)    bus_rdata <= stage;
    else if (ops.rd_other) bus_rdata <= '0;
  end

  assign cnt_out = cnt;

  // R7
  rd_lo_data_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ops.rd_lo)) |-> bus_rdata == $past(cnt[DATA_W-1:0]));
  // R8
  rd_hi_data_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ops.rd_hi)) |-> bus_rdata == $past(stage));
  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q));
  // R13
  wr_blocks_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_wr)) |-> $stable(bus_rdata));
endmodule

// File: tb/wordreg_bridge_test.sv
module wordreg_bridge_test;
  localparam logic [3:0] LO = 4'h4;
  localparam logic [3:0] HI = 4'h5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lo_first = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [15:0] cnt_out;

  int n_chk = 0, n_bad = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  // independent reference state
  logic [15:0] m_cnt;
  logic [7:0]  m_stage, m_rdata;
  logic        m_mode;

  always #2.5 clk = ~clk;

  wordreg_bridge uut (.clk(clk), .rst(rst), .lo_first(lo_first), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .cnt_out(cnt_out));

  function automatic logic is_commit(logic mode, logic w, logic [3:0] a);
    return w && (mode ? (a == HI) : (a == LO));
  endfunction
  function automatic logic is_fill(logic mode, logic w, logic [3:0] a);
    return w && (mode ? (a == LO) : (a == HI));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= '0; m_stage <= '0; m_rdata <= '0; m_mode <= lo_first;
    end else begin
      if (is_commit(m_mode, bus_wr, bus_addr))
        m_cnt <= m_mode ? {bus_wdata, m_stage} : {m_stage, bus_wdata};
      else
        m_cnt <= m_cnt + 16'd1;
      if (bus_rd && !bus_wr && bus_addr == LO) m_stage <= m_cnt[15:8];
      else if (is_fill(m_mode, bus_wr, bus_addr)) m_stage <= bus_wdata;
      if (bus_rd && !bus_wr)
        m_rdata <= (bus_addr == LO) ? m_cnt[7:0] : (bus_addr == HI) ? m_stage : 8'h00;
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(cnt_out, m_cnt, "R2/R6 model counter");
      chk({8'h0, bus_rdata}, {8'h0, m_rdata}, "R7/R8 model rdata");
    end
  end

  task automatic op(input logic w, input logic r, input logic [3:0] a, input logic [7:0] d);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic do_reset(input logic mode);
    cmp_en = 1'b0;
    rst = 1'b1; lo_first = mode;
    repeat (3) @(negedge clk);
    chk(cnt_out, 16'h0, "R1 counter in reset");
    chk({8'h0, bus_rdata}, 16'h0, "R1 rdata in reset");
    rst = 1'b0;
    @(negedge clk);
    cmp_en = 1'b1;
  endtask

  task automatic random_run(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      int sel = $urandom_range(0, 9);
      logic [3:0] a = ($urandom_range(0, 3) == 0) ? 4'($urandom) : ($urandom_range(0, 1) ? LO : HI);
      logic [7:0] d = 8'($urandom);
      case (sel)
        0, 1, 2: op(1'b1, 1'b0, a, d);
        3, 4, 5: op(1'b0, 1'b1, a, d);
        6:       op(1'b1, 1'b1, a, d);
        default: op(1'b0, 1'b0, a, d);
      endcase
    end
  endtask

  initial begin
    logic [15:0] c;
    logic [7:0] prev;
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset(1'b0);
    // high-first ordering
    c = cnt_out; op(1'b1, 1'b0, HI, 8'hAB);
    chk(cnt_out, c + 16'd1, "R3 fill leaves counter counting");
    op(1'b1, 1'b0, LO, 8'hCD);
    chk(cnt_out, 16'hABCD, "R4 commit high-first");
    op(1'b0, 1'b0, 4'h0, 8'h00);
    chk(cnt_out, 16'hABCE, "R6 counts on after commit");
    op(1'b1, 1'b0, HI, 8'h12); op(1'b1, 1'b0, LO, 8'hFE);
    op(1'b0, 1'b1, LO, 8'h00);
    chk({8'h0, bus_rdata}, 16'h00FE, "R7 low read returns live low");
    op(1'b0, 1'b0, 4'h0, 8'h00);
    op(1'b0, 1'b1, HI, 8'h00);
    chk({8'h0, bus_rdata}, 16'h0012, "R8 high read returns captured byte");
    chk({8'h0, cnt_out[15:8]}, 16'h0013, "R8 live high differs");
    // R9 shared latch overwritten by read
    op(1'b1, 1'b0, HI, 8'h77);
    c = cnt_out; op(1'b0, 1'b1, LO, 8'h00);
    op(1'b1, 1'b0, LO, 8'h55);
    chk(cnt_out, {c[15:8], 8'h55}, "R9 read replaces pending byte");
    // R10 wrong order: low write without fill
    op(1'b1, 1'b0, LO, 8'h99);
    chk(cnt_out, {c[15:8], 8'h99}, "R10 stale latch used");
    // R12 unmapped address
    c = cnt_out; op(1'b1, 1'b0, 4'h0, 8'hEE);
    chk(cnt_out, c + 16'd1, "R12 unmapped write ignored");
    op(1'b0, 1'b1, 4'hF, 8'h00);
    chk({8'h0, bus_rdata}, 16'h0, "R12 unmapped read returns 0");
    op(1'b1, 1'b0, LO, 8'h42);
    chk(cnt_out, {c[15:8], 8'h42}, "R12 latch untouched by unmapped write");
    // R13 both strobes
    op(1'b0, 1'b1, LO, 8'h00); prev = bus_rdata;
    op(1'b1, 1'b1, HI, 8'h3C);
    chk({8'h0, bus_rdata}, {8'h0, prev}, "R13 read ignored with write");
    op(1'b1, 1'b0, LO, 8'h01);
    chk(cnt_out, 16'h3C01, "R13 write performed");
    // R2 wrap
    op(1'b1, 1'b0, HI, 8'hFF); op(1'b1, 1'b0, LO, 8'hFF);
    op(1'b0, 1'b0, 4'h0, 8'h00);
    chk(cnt_out, 16'h0000, "R2 wraps to zero");
    random_run(3000);
    // low-first ordering, R11 input flipped after reset
    do_reset(1'b1);
    lo_first = 1'b0;
    c = cnt_out; op(1'b1, 1'b0, LO, 8'h11);
    chk(cnt_out, c + 16'd1, "R5 low fill leaves counter counting");
    op(1'b1, 1'b0, HI, 8'h22);
    chk(cnt_out, 16'h2211, "R5/R11 low-first commit");
    random_run(3000);
    lo_first = 1'b1;
    do_reset(1'b0);
    lo_first = 1'b1;
    op(1'b1, 1'b0, HI, 8'h5A); op(1'b1, 1'b0, LO, 8'hA5);
    chk(cnt_out, 16'h5AA5, "R11 high-first kept after input change");
    random_run(2000);
    cmp_en = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule